// File: doc/BRIEF.md
# Grouped-Priority Interrupt Arbiter

This block looks at a set of interrupt request lines, each with its own 8-bit priority, and picks the request that should be serviced next. It also reports whether that request may interrupt the handler that is running now. In every priority value, a lower number means more urgent. A binary-point setting splits each 8-bit priority into two fields. The upper bits form the group field and the lower bits form the subpriority.

Two masking controls decide which pending requests can be taken. A global mask blocks every request. A base threshold admits only requests whose priority value is below it, and a threshold of zero turns this filter off. Among the requests that pass, the most urgent group wins. A tie in group is broken by the lower subpriority, and a remaining tie by the lower request index. A preempt request is raised when there is a winner and either no handler is active (thread mode) or the winner's group is strictly more urgent than the group of the active handler.

The outputs are registered. They reflect the inputs that were present at the previous rising clock edge.

Top module: `irq_group_arbiter`

## Requirements
- R1: While `rst_n` is low, `winValid`, `winIrq` and `preemptReq` are all zero. Reset is asynchronous.
- R2: With binary point b (0..7), bits [7:b+1] of a priority form the group field and bits [b:0] form the subpriority. With b = 7 the group field is empty, so every request is in the same group.
- R3: Among the eligible requests, the one with the numerically lowest group field wins, whatever its index or subpriority.
- R4: Among eligible requests with equal group fields, the one with the lower subpriority wins.
- R5: When the group and subpriority of two requests are both equal, the lower request index wins.
- R6: While `globalMask` is 1, no request is eligible: `winValid` and `preemptReq` are 0.
- R7: When `basePri` is non-zero, a request is eligible only if its full 8-bit priority is numerically below `basePri`. When `basePri` is zero, no threshold applies.
- R8: In thread mode (`threadMode` = 1), a valid winner always raises `preemptReq`.
- R9: In handler mode, `preemptReq` is 1 only if the winner's group field is strictly lower than the group field of `activePrio`, both taken under the current binary point. An equal group gives 0.
- R10: The outputs change exactly one rising clock edge after the inputs change. They take the values computed from the inputs sampled at that edge.
- R11: With no eligible request, `winValid` = 0, `winIrq` = 0 and `preemptReq` = 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pendVec | input | NUM_IRQ | Pending request lines, one per interrupt |
| prioFlat | input | NUM_IRQ*8 | Priorities; request i uses bits [8i+7:8i] |
| binPoint | input | 3 | Group/subpriority split point b |
| activePrio | input | 8 | Priority of the handler currently running |
| threadMode | input | 1 | 1 when no handler is active |
| globalMask | input | 1 | 1 blocks all requests |
| basePri | input | 8 | Eligibility threshold; 0 disables it |
| winIrq | output | $clog2(NUM_IRQ) | Index of the winning request |
| winValid | output | 1 | An eligible request exists |
| preemptReq | output | 1 | The winner may enter now |

## Verification
The bench gives lower indices worse groups, so a design that picked by index first, or that compared subpriority before group, would name the wrong request. It moves the binary point around one fixed pair of priorities, so the same pair is in one group at one setting and in two groups at another. A design with an off-by-one split would raise or drop the preempt at the wrong setting. It places a priority exactly at the threshold, which an inclusive compare would wrongly admit. It also presents a winner whose group equals the active group, where a design comparing full values or using non-strict order would preempt by mistake. Finally, it checks that the output holds its previous value until the next clock edge and that reset clears all outputs.

// File: rtl/irq_arb_pkg.sv
package irq_arb_pkg;
  localparam int PRIO_W = 8;
  localparam int BP_W   = $clog2(PRIO_W);
  localparam int SH_W   = BP_W + 1;

  typedef struct packed {
    logic [PRIO_W-1:0] grpMask;
    logic              thrEn;
    logic [PRIO_W-1:0] thrVal;
    logic              maskAll;
  } arbCtrlT;
endpackage

// File: rtl/irq_arb_ctrl.sv
module irq_arb_ctrl
  import irq_arb_pkg::*;
#(
  parameter int NUM_IRQ = 8,
  localparam int IDX_W  = $clog2(NUM_IRQ)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [BP_W-1:0]   binPoint,
  input  logic              globalMask,
  input  logic [PRIO_W-1:0] basePri,
  input  logic              threadMode,
  input  logic [PRIO_W-1:0] activePrio,
  input  logic              candValid,
  input  logic [IDX_W-1:0]  candIdx,
  input  logic [PRIO_W-1:0] candGroup,
  output arbCtrlT           ctrl,
  output logic [IDX_W-1:0]  winIrq,
  output logic              winValid,
  output logic              preemptReq
);
  logic [SH_W-1:0]   shAmt;
  logic [PRIO_W-1:0] activeGroup;
  logic              preemptNext;

  // Group field occupies the bits above the binary point.
  always_comb begin
    shAmt        = SH_W'(binPoint) + SH_W'(1);
    ctrl.grpMask = {PRIO_W{1'b1}} << shAmt;
    ctrl.thrEn   = (basePri != '0);
    ctrl.thrVal  = basePri;
    ctrl.maskAll = globalMask;
  end

  always_comb begin
    activeGroup = activePrio & ctrl.grpMask;
    preemptNext = candValid && (threadMode || (candGroup < activeGroup));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      winValid   <= 1'b0;
      winIrq     <= '0;
      preemptReq <= 1'b0;
    end else begin
      winValid   <= candValid;
      winIrq     <= candValid ? candIdx : '0;
      preemptReq <= preemptNext;
    end
  end
endmodule

// File: rtl/irq_arb_datapath.sv
module irq_arb_datapath
  import irq_arb_pkg::*;
#(
  parameter int NUM_IRQ = 8,
  localparam int IDX_W  = $clog2(NUM_IRQ)
) (
  input  logic [NUM_IRQ-1:0]        pendVec,
  input  logic [NUM_IRQ*PRIO_W-1:0] prioFlat,
  input  arbCtrlT                   ctrl,
  output logic                      candValid,
  output logic [IDX_W-1:0]          candIdx,
  output logic [PRIO_W-1:0]         candGroup
);
  logic [NUM_IRQ-1:0] elig;
  logic               chainV   [NUM_IRQ];
  logic [IDX_W-1:0]   chainIdx [NUM_IRQ];
  logic [PRIO_W-1:0]  chainGrp [NUM_IRQ];
  logic [PRIO_W-1:0]  chainSub [NUM_IRQ];

  for (genvar i = 0; i < NUM_IRQ; i++) begin : g_stage
    logic [PRIO_W-1:0] prio, grp, sub;
    logic              take;

    always_comb begin
      prio    = prioFlat[i*PRIO_W +: PRIO_W];
      grp     = prio & ctrl.grpMask;
      sub     = prio & ~ctrl.grpMask;
      elig[i] = pendVec[i] & ~ctrl.maskAll & (~ctrl.thrEn | (prio < ctrl.thrVal));
    end

    if (i == 0) begin : g_first
      always_comb begin
        take        = elig[0];
        chainV[0]   = elig[0];
        chainIdx[0] = '0;
        chainGrp[0] = grp;
        chainSub[0] = sub;
      end
    end else begin : g_next
      // Strict compares keep the earlier (lower) index on a full tie.
      always_comb begin
        take = elig[i] & (~chainV[i-1]
                          | (grp < chainGrp[i-1])
                          | ((grp == chainGrp[i-1]) & (sub < chainSub[i-1])));
        chainV[i]   = chainV[i-1] | elig[i];
        chainIdx[i] = take ? IDX_W'(i) : chainIdx[i-1];
        chainGrp[i] = take ? grp : chainGrp[i-1];
        chainSub[i] = take ? sub : chainSub[i-1];
      end
    end
  end

  assign candValid = chainV[NUM_IRQ-1];
  assign candIdx   = chainIdx[NUM_IRQ-1];
  assign candGroup = chainGrp[NUM_IRQ-1];
endmodule

// File: rtl/irq_group_arbiter.sv
module irq_group_arbiter
  import irq_arb_pkg::*;
#(
  parameter int NUM_IRQ = 8,
  localparam int IDX_W  = $clog2(NUM_IRQ)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [NUM_IRQ-1:0]        pendVec,
  input  logic [NUM_IRQ*PRIO_W-1:0] prioFlat,
  input  logic [BP_W-1:0]           binPoint,
  input  logic [PRIO_W-1:0]         activePrio,
  input  logic                      threadMode,
  input  logic                      globalMask,
  input  logic [PRIO_W-1:0]         basePri,
  output logic [IDX_W-1:0]          winIrq,
  output logic                      winValid,
  output logic                      preemptReq
);
  arbCtrlT           ctrl;
  logic              candValid;
  logic [IDX_W-1:0]  candIdx;
  logic [PRIO_W-1:0] candGroup;

  irq_arb_datapath #(.NUM_IRQ(NUM_IRQ)) u_dp (
    .pendVec   (pendVec),
    .prioFlat  (prioFlat),
    .ctrl      (ctrl),
    .candValid (candValid),
    .candIdx   (candIdx),
    .candGroup (candGroup)
  );

  irq_arb_ctrl #(.NUM_IRQ(NUM_IRQ)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .binPoint   (binPoint),
    .globalMask (globalMask),
    .basePri    (basePri),
    .threadMode (threadMode),
    .activePrio (activePrio),
    .candValid  (candValid),
    .candIdx    (candIdx),
    .candGroup  (candGroup),
    .ctrl       (ctrl),
    .winIrq     (winIrq),
    .winValid   (winValid),
    .preemptReq (preemptReq)
  );
endmodule

// File: rtl/irq_arb_checker.sv
module irq_arb_checker
  import irq_arb_pkg::*;
#(
  parameter int NUM_IRQ = 8,
  localparam int IDX_W  = $clog2(NUM_IRQ)
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic [NUM_IRQ-1:0]        pendVec,
  input logic [NUM_IRQ*PRIO_W-1:0] prioFlat,
  input logic [BP_W-1:0]           binPoint,
  input logic [PRIO_W-1:0]         activePrio,
  input logic                      threadMode,
  input logic                      globalMask,
  input logic [PRIO_W-1:0]         basePri,
  input logic [IDX_W-1:0]          winIrq,
  input logic                      winValid,
  input logic                      preemptReq
);
  logic                      primed;
  logic [NUM_IRQ-1:0]        prevPend;
  logic [NUM_IRQ*PRIO_W-1:0] prevPrio;
  logic [BP_W-1:0]           prevBp;
  logic [PRIO_W-1:0]         prevAct, prevBase;
  logic                      prevThr, prevMask;
  logic [PRIO_W-1:0]         winPrio, gm;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      primed   <= 1'b0;
      prevPend <= '0;
      prevPrio <= '0;
      prevBp   <= '0;
      prevAct  <= '0;
      prevBase <= '0;
      prevThr  <= 1'b0;
      prevMask <= 1'b0;
    end else begin
      primed   <= 1'b1;
      prevPend <= pendVec;
      prevPrio <= prioFlat;
      prevBp   <= binPoint;
      prevAct  <= activePrio;
      prevBase <= basePri;
      prevThr  <= threadMode;
      prevMask <= globalMask;
    end
  end

  always_comb begin
    winPrio = prevPrio[winIrq*PRIO_W +: PRIO_W];
    gm      = {PRIO_W{1'b1}} << (SH_W'(prevBp) + SH_W'(1));
  end

  a_r11_valid_has_pending: assert property (@(posedge clk) disable iff (!rst_n || !primed)
    winValid |-> prevPend[winIrq]);
  a_r11_idle_outputs_zero: assert property (@(posedge clk) disable iff (!rst_n || !primed)
    !winValid |-> (winIrq == '0) && !preemptReq);
  a_r6_mask_blocks_all: assert property (@(posedge clk) disable iff (!rst_n || !primed)
    prevMask |-> !winValid && !preemptReq);
  a_r7_below_threshold: assert property (@(posedge clk) disable iff (!rst_n || !primed)
    (winValid && prevBase != '0) |-> (winPrio < prevBase));
  a_r8_thread_enters: assert property (@(posedge clk) disable iff (!rst_n || !primed)
    (winValid && prevThr) |-> preemptReq);
  a_r9_equal_group_holds: assert property (@(posedge clk) disable iff (!rst_n || !primed)
    (winValid && !prevThr && ((winPrio & gm) == (prevAct & gm))) |-> !preemptReq);
  a_r9_preempt_needs_winner: assert property (@(posedge clk) disable iff (!rst_n || !primed)
    preemptReq |-> winValid);
endmodule

bind irq_group_arbiter irq_arb_checker #(.NUM_IRQ(NUM_IRQ)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .pendVec    (pendVec),
  .prioFlat   (prioFlat),
  .binPoint   (binPoint),
  .activePrio (activePrio),
  .threadMode (threadMode),
  .globalMask (globalMask),
  .basePri    (basePri),
  .winIrq     (winIrq),
  .winValid   (winValid),
  .preemptReq (preemptReq)
);

// File: tb/tb_irq_group_arbiter.sv
`timescale 1ns/1ps
module tb_irq_group_arbiter;
  localparam int N = 4;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [N-1:0] pendVec = '0;
  logic [31:0]  prioFlat = '0;
  logic [2:0]   binPoint = '0;
  logic [7:0]   activePrio = '0;
  logic         threadMode = 1'b0;
  logic         globalMask = 1'b0;
  logic [7:0]   basePri = '0;
  logic [1:0]   winIrq;
  logic         winValid;
  logic         preemptReq;

  int  nChecks = 0;
  int  nFails  = 0;
  bit  done    = 1'b0;

  always #5 clk = ~clk;

  irq_group_arbiter #(.NUM_IRQ(N)) dut (
    .clk(clk), .rst_n(rst_n), .pendVec(pendVec), .prioFlat(prioFlat),
    .binPoint(binPoint), .activePrio(activePrio), .threadMode(threadMode),
    .globalMask(globalMask), .basePri(basePri), .winIrq(winIrq),
    .winValid(winValid), .preemptReq(preemptReq)
  );

  typedef struct packed {
    logic [3:0]  pend;
    logic [31:0] prio;   // {p3,p2,p1,p0}
    logic [2:0]  bp;
    logic [7:0]  act;
    logic        thr;
    logic        gmask;
    logic [7:0]  base;
    logic        eV;
    logic [1:0]  eI;
    logic        eP;
    logic [3:0]  req;
  } vecT;

  localparam int NV = 15;
  localparam vecT VECS [NV] = '{
    '{4'h0, 32'h40302010, 3'd0, 8'hFF, 1'b0, 1'b0, 8'h00, 1'b0, 2'd0, 1'b0, 4'd11}, // R11 none pending
    '{4'hF, 32'h40302010, 3'd0, 8'hFF, 1'b0, 1'b0, 8'h00, 1'b1, 2'd0, 1'b1, 4'd3},  // R3 best group
    '{4'hF, 32'h29272225, 3'd3, 8'hFF, 1'b0, 1'b0, 8'h00, 1'b1, 2'd1, 1'b1, 4'd4},  // R4 sub decides
    '{4'hE, 32'h40404040, 3'd0, 8'h40, 1'b0, 1'b0, 8'h00, 1'b1, 2'd1, 1'b0, 4'd5},  // R5 index tie, R9 equal
    '{4'h3, 32'h00001080, 3'd7, 8'h00, 1'b0, 1'b0, 8'h00, 1'b1, 2'd1, 1'b0, 4'd2},  // R2 b=7 one group
    '{4'h2, 32'h00002100, 3'd4, 8'h30, 1'b0, 1'b0, 8'h00, 1'b1, 2'd1, 1'b0, 4'd2},  // R2 b=4 same group
    '{4'h2, 32'h00002100, 3'd3, 8'h30, 1'b0, 1'b0, 8'h00, 1'b1, 2'd1, 1'b1, 4'd2},  // R2 b=3 split
    '{4'hF, 32'h40302010, 3'd0, 8'hFF, 1'b0, 1'b1, 8'h00, 1'b0, 2'd0, 1'b0, 4'd6},  // R6 global mask
    '{4'hE, 32'h40302010, 3'd0, 8'hFF, 1'b0, 1'b0, 8'h20, 1'b0, 2'd0, 1'b0, 4'd7},  // R7 at threshold
    '{4'hF, 32'h40302010, 3'd0, 8'hFF, 1'b0, 1'b0, 8'h20, 1'b1, 2'd0, 1'b1, 4'd7},  // R7 below
    '{4'hE, 32'h40302010, 3'd0, 8'hFF, 1'b0, 1'b0, 8'h31, 1'b1, 2'd1, 1'b1, 4'd7},  // R7 raised
    '{4'h4, 32'h40302010, 3'd0, 8'h00, 1'b1, 1'b0, 8'h00, 1'b1, 2'd2, 1'b1, 4'd8},  // R8 thread
    '{4'h4, 32'h40302010, 3'd0, 8'h10, 1'b0, 1'b0, 8'h00, 1'b1, 2'd2, 1'b0, 4'd9},  // R9 less urgent
    '{4'hF, 32'h50607080, 3'd0, 8'hFF, 1'b1, 1'b0, 8'h00, 1'b1, 2'd3, 1'b1, 4'd3},  // R3 high index wins
    '{4'h3, 32'h00002F30, 3'd3, 8'hFF, 1'b0, 1'b0, 8'h00, 1'b1, 2'd1, 1'b1, 4'd3}   // R3 group over sub
  };

  task automatic check(input int req, input logic v, input logic [1:0] i, input logic p);
    nChecks++;
    if (winValid !== v || winIrq !== i || preemptReq !== p) begin
      nFails++;
      $display("FAIL R%0d: got valid=%0b irq=%0d pre=%0b, expected valid=%0b irq=%0d pre=%0b",
               req, winValid, winIrq, preemptReq, v, i, p);
    end
  endtask

  task automatic apply(input vecT t);
    pendVec = t.pend; prioFlat = t.prio; binPoint = t.bp; activePrio = t.act;
    threadMode = t.thr; globalMask = t.gmask; basePri = t.base;
  endtask

  initial begin
    repeat (2) @(negedge clk);
    check(1, 1'b0, 2'd0, 1'b0);  // R1 in reset
    rst_n = 1'b1;
    @(negedge clk);
    check(11, 1'b0, 2'd0, 1'b0); // R11 idle after reset

    for (int k = 0; k < NV; k++) begin
      apply(VECS[k]);
      @(negedge clk);
      check(int'(VECS[k].req), VECS[k].eV, VECS[k].eI, VECS[k].eP);
    end

    // R10: one-edge latency
    apply('{4'h4, 32'h40302010, 3'd0, 8'hFF, 1'b1, 1'b0, 8'h00, 1'b0, 2'd0, 1'b0, 4'd10});
    @(negedge clk);
    check(10, 1'b1, 2'd2, 1'b1);
    pendVec = 4'h8;
    #1 check(10, 1'b1, 2'd2, 1'b1);  // not yet clocked
    @(negedge clk);
    check(10, 1'b1, 2'd3, 1'b1);

    // R1: asynchronous reset mid-run
    rst_n = 1'b0;
    #1 check(1, 1'b0, 2'd0, 1'b0);
    @(negedge clk);
    check(1, 1'b0, 2'd0, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    check(10, 1'b1, 2'd3, 1'b1);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end
endmodule